// File: doc/BRIEF.md
# Write-back MSI snooping line controller

This block keeps one cache line coherent in a write-back, write-allocate cache that shares a snooping bus with other caches. The line is in one of three states: Invalid, Shared (clean and read-only) or Exclusive (the only copy, writable and dirty). Processor reads and writes that hit finish at once. Misses, upgrades and evictions need bus ownership, which is requested with a single request/grant pair. Once granted, the block puts a write-back of the dirty victim on the bus if one is needed, and then a read miss or write miss for the wanted block.

The block also watches the misses that other caches place on the bus. A snooped write miss to a line it holds drops that line to Invalid. A snooped miss that finds the line dirty makes this cache supply the block on its snoop data output and raise an abort so that memory does not answer. The line then drops to Shared after a read miss, or to Invalid after a write miss. The line contents change only after the grant arrives. For that reason, a request that waits for the bus decides whether it needs a write-back and what it finally issues from the line state at the moment of the grant, after any snoops that came while it waited.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: During and directly after reset the line is Invalid, and busReq, cpuDone and abortMem are 0 with busCmd idle (2'b00).
- R2: With no snoop present, a read to the held address in Shared or Exclusive raises cpuDone in the same cycle it is presented. cpuRdata carries the line data, and busReq stays low.
- R3: Bus commands are 2'b00 idle, 2'b01 read miss, 2'b10 write miss and 2'b11 write-back, and they are driven only while busGrant is high. A read that misses on an Invalid line requests the bus. After the grant it drives one read-miss cycle with the address, and cpuDone rises in that cycle with cpuRdata equal to busRdata. The line ends in Shared.
- R4: A write to an Invalid line issues one write miss and leaves the line Exclusive, holding the written data. A further write to that line completes in its first cycle with no bus command.
- R5: A write to a Shared line issues a write miss for that address and moves the line to Exclusive. Later writes then cause no bus traffic.
- R6: A snooped write miss that matches a Shared line does not raise abortMem and moves the line to Invalid, so the next read issues a read miss.
- R7: A snooped read miss that matches an Exclusive line raises abortMem in that cycle with snpData equal to the line data. The line then becomes Shared, so a read still hits and a write issues a write miss.
- R8: A snooped write miss that matches an Exclusive line raises abortMem with the line data on snpData and moves the line to Invalid.
- R9: A read miss that displaces an Exclusive line first drives a write-back cycle with the old address and data, then a read miss for the new address. The line ends Shared.
- R10: A write miss that displaces an Exclusive line drives a write-back of the old block, then a write miss for the new address. The line stays Exclusive with the new data.
- R11: The line tag does not change while busGrant is low. A snoop that arrives while a request waits for the grant is applied, and the request's bus sequence is chosen from the resulting state: a victim downgraded to Shared is not written back. Snoops to other addresses raise no abort.
- R12: In a cycle where snpValid is high, a processor request is held and cpuDone stays low. It completes after the snoop is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request held until cpuDone |
| cpuWrite | input | 1 | 1 for write, 0 for read |
| cpuAddr | input | ADDR_W | Block address of the request |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on reads |
| busReq | output | 1 | Bus ownership request, held through the transaction |
| busGrant | input | 1 | Bus ownership grant |
| busCmd | output | 2 | Command driven while granted |
| busAddr | output | ADDR_W | Address of the driven command |
| busWdata | output | DATA_W | Block data of a write-back |
| busRdata | input | DATA_W | Block data returned in a miss cycle |
| snpValid | input | 1 | Another cache's command is on the bus |
| snpCmd | input | 2 | Snooped command, same coding as busCmd |
| snpAddr | input | ADDR_W | Snooped block address |
| abortMem | output | 1 | This cache supplies the block; memory must not answer |
| snpData | output | DATA_W | Dirty block supplied to the snooper |

## Verification
The processor side is exercised with hits, with misses from Invalid, with Shared-to-Exclusive upgrades and with dirty evictions by both reads and writes. These cases tell apart the single-cycle path, the single miss cycle and the write-back-then-miss pair. A scoreboard matches each expected bus command, address and write-back data in order, so a missing or extra write-back shows up directly. Snoops of each kind are applied to Shared lines, to Exclusive lines and to other addresses, and the resulting state is then probed through the processor port: a read that hits or misses, or a write that stays quiet or goes to the bus. Snoops that arrive while the grant is withheld show whether the pending sequence is chosen at grant time.

// File: rtl/msi_snoop_pkg.sv
`timescale 1ns/1ps
package msi_snoop_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_RDMISS = 2'd1,
    CMD_WRMISS = 2'd2,
    CMD_WBACK  = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_ARB  = 2'd1,
    C_WBK  = 2'd2,
    C_MISS = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic       loadState;
    lineState_t nextState;
    logic       loadTag;
    logic       loadData;
    logic       dataFromBus;
  } lineStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strb,
  input  logic [ADDR_W-1:0] newTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  output lineState_t        lineState,
  output logic [ADDR_W-1:0] lineTag,
  output logic [DATA_W-1:0] lineData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineState <= LINE_INV;
      lineTag   <= '0;
      lineData  <= '0;
    end else begin
      if (strb.loadState) lineState <= strb.nextState;
      if (strb.loadTag)   lineTag   <= newTag;
      if (strb.loadData)  lineData  <= strb.dataFromBus ? busRdata : cpuWdata;
    end
  end

  // R4: a line never becomes Exclusive without a tag or data load in the same step
  assert_excl_entry_loads_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadState && strb.nextState == LINE_EXC && lineState == LINE_INV) |-> strb.loadData);

endmodule

// File: rtl/msi_line_ctrl.sv
`timescale 1ns/1ps
module msi_line_ctrl
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              abortMem,
  output logic [DATA_W-1:0] snpData,
  input  lineState_t        lineState,
  input  logic [ADDR_W-1:0] lineTag,
  input  logic [DATA_W-1:0] lineData,
  output lineStrobe_t       strb
);

  ctrlState_t ctrlQ, ctrlD;

  logic tagHit, snpMatch, snpRd, snpWr, ownBus, needWb;

  always_comb begin
    tagHit   = (lineState != LINE_INV) && (lineTag == cpuAddr);
    ownBus   = (ctrlQ == C_WBK) || (ctrlQ == C_MISS);
    snpMatch = snpValid && !ownBus && (lineState != LINE_INV) && (lineTag == snpAddr);
    snpRd    = snpMatch && (snpCmd == CMD_RDMISS);
    snpWr    = snpMatch && (snpCmd == CMD_WRMISS);
    needWb   = (lineState == LINE_EXC) && (lineTag != cpuAddr);
  end

  always_comb begin
    ctrlD    = ctrlQ;
    strb     = '0;
    cpuDone  = 1'b0;
    cpuRdata = '0;
    busReq   = 1'b0;
    busCmd   = CMD_IDLE;
    busAddr  = '0;
    busWdata = '0;
    abortMem = 1'b0;
    snpData  = '0;

    // snooped misses from other caches
    if ((snpRd || snpWr) && lineState == LINE_EXC) begin
      abortMem = 1'b1;
      snpData  = lineData;
    end
    if (snpWr) begin
      strb.loadState = 1'b1;
      strb.nextState = LINE_INV;
    end else if (snpRd && lineState == LINE_EXC) begin
      strb.loadState = 1'b1;
      strb.nextState = LINE_SHR;
    end

    unique case (ctrlQ)
      C_IDLE: begin
        if (cpuReq && !snpValid) begin
          if (tagHit && (!cpuWrite || lineState == LINE_EXC)) begin
            cpuDone       = 1'b1;
            cpuRdata      = lineData;
            strb.loadData = cpuWrite;
          end else begin
            ctrlD = C_ARB;
          end
        end
      end
      C_ARB: begin
        busReq = 1'b1;
        if (busGrant) ctrlD = needWb ? C_WBK : C_MISS;
      end
      C_WBK: begin
        busReq   = 1'b1;
        busCmd   = CMD_WBACK;
        busAddr  = lineTag;
        busWdata = lineData;
        ctrlD    = C_MISS;
      end
      C_MISS: begin
        busReq           = 1'b1;
        busCmd           = cpuWrite ? CMD_WRMISS : CMD_RDMISS;
        busAddr          = cpuAddr;
        cpuDone          = 1'b1;
        cpuRdata         = cpuWrite ? '0 : busRdata;
        strb.loadState   = 1'b1;
        strb.nextState   = cpuWrite ? LINE_EXC : LINE_SHR;
        strb.loadTag     = 1'b1;
        strb.loadData    = 1'b1;
        strb.dataFromBus = !cpuWrite;
        ctrlD            = C_IDLE;
      end
      default: ctrlD = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= C_IDLE;
    else       ctrlQ <= ctrlD;
  end

  // R3: commands appear on the bus only under a grant
  assert_cmd_under_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd != CMD_IDLE) |-> busGrant);

  // R9: a write-back is always followed by the miss it makes room for
  assert_wback_then_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd == CMD_WBACK) |=> (busCmd == CMD_RDMISS || busCmd == CMD_WRMISS));

  // R7: supplying dirty data leaves this cache without the dirty copy
  assert_abort_drops_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    abortMem |=> (lineState != LINE_EXC));

  // R2: a completion without the bus only comes from a valid line
  assert_hit_needs_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && !busReq) |-> (lineState != LINE_INV));

  // R12: a snoop cycle never completes a processor access
  assert_snoop_stalls_cpu_R12: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && !busGrant) |-> !cpuDone);

endmodule

// File: rtl/msi_snoop_ctrl.sv
`timescale 1ns/1ps
module msi_snoop_ctrl
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              abortMem,
  output logic [DATA_W-1:0] snpData
);

  lineStrobe_t       strb;
  lineState_t        lineState;
  logic [ADDR_W-1:0] lineTag;
  logic [DATA_W-1:0] lineData;

  msi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGrant(busGrant), .busCmd(busCmd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .abortMem(abortMem), .snpData(snpData),
    .lineState(lineState), .lineTag(lineTag), .lineData(lineData),
    .strb(strb)
  );

  msi_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .newTag(cpuAddr), .cpuWdata(cpuWdata), .busRdata(busRdata),
    .lineState(lineState), .lineTag(lineTag), .lineData(lineData)
  );

  // R11: the held block identity is frozen whenever the bus is not owned
  assert_tag_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busGrant |=> $stable(lineTag));

endmodule

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic        cpuDone;
  logic [15:0] cpuRdata;
  logic        busReq, busGrant;
  logic [1:0]  busCmd;
  logic [7:0]  busAddr;
  logic [15:0] busWdata, busRdata;
  logic        snpValid = 1'b0;
  logic [1:0]  snpCmd = '0;
  logic [7:0]  snpAddr = '0;
  logic        abortMem;
  logic [15:0] snpData;
  logic        allowGrant = 1'b1;

  always #5 clk = ~clk;

  assign busGrant = busReq & allowGrant;
  assign busRdata = {busAddr, ~busAddr};

  msi_snoop_ctrl u_msi_snoop_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGrant(busGrant), .busCmd(busCmd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .abortMem(abortMem), .snpData(snpData)
  );

  typedef struct {
    logic [1:0]  cmd;
    logic [7:0]  addr;
    logic [15:0] data;
    string       req;
  } busItem_t;

  busItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expectBus(logic [1:0] cmd, logic [7:0] addr, logic [15:0] data, string req);
    busItem_t it;
    it.cmd = cmd; it.addr = addr; it.data = data; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: pops the scoreboard as bus commands appear
  always @(negedge clk) begin
    if (rstN && busCmd != 2'b00) begin
      if (expQ.size() == 0) begin
        check("R2", "unexpected bus command", {30'd0, busCmd}, 32'd0);
      end else begin
        busItem_t it;
        it = expQ.pop_front();
        check(it.req, "bus command", {30'd0, busCmd}, {30'd0, it.cmd});
        check(it.req, "bus address", {24'd0, busAddr}, {24'd0, it.addr});
        if (it.cmd == 2'b11)
          check(it.req, "write-back data", {16'd0, busWdata}, {16'd0, it.data});
      end
    end
  end

  task automatic cpuOp(bit wr, logic [7:0] a, logic [15:0] wd, bit expHit,
                       logic [15:0] expRd, string req);
    int waited;
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    waited = 0;
    while (1) begin
      @(negedge clk);
      if (cpuDone) break;
      waited++;
      if (waited > 50) break;
    end
    check(req, "completion seen", {31'd0, cpuDone}, 32'd1);
    if (expHit) check(req, "cycles to hit", waited, 0);
    if (!wr) check(req, "read data", {16'd0, cpuRdata}, {16'd0, expRd});
    @(posedge clk); #1;
    cpuReq = 1'b0;
  endtask

  task automatic snoopOp(logic [1:0] cmd, logic [7:0] a, bit expAbort,
                         logic [15:0] expData, string req);
    @(posedge clk); #1;
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a;
    @(negedge clk);
    check(req, "abort", {31'd0, abortMem}, {31'd0, expAbort});
    if (expAbort) check(req, "supplied data", {16'd0, snpData}, {16'd0, expData});
    @(posedge clk); #1;
    snpValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "busReq in reset", {31'd0, busReq}, 32'd0);
    check("R1", "busCmd in reset", {30'd0, busCmd}, 32'd0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "abortMem after reset", {31'd0, abortMem}, 32'd0);
    check("R1", "cpuDone after reset", {31'd0, cpuDone}, 32'd0);
    check("R1", "busReq after reset", {31'd0, busReq}, 32'd0);

    // R3: read miss from Invalid
    expectBus(2'b01, 8'h10, 16'h0, "R3");
    cpuOp(0, 8'h10, 16'h0, 0, 16'h10EF, "R3");
    cpuOp(0, 8'h10, 16'h0, 1, 16'h10EF, "R2");
    // R5: upgrade from Shared
    expectBus(2'b10, 8'h10, 16'h0, "R5");
    cpuOp(1, 8'h10, 16'hAAAA, 0, 16'h0, "R5");
    cpuOp(1, 8'h10, 16'hBBBB, 1, 16'h0, "R5");
    cpuOp(0, 8'h10, 16'h0, 1, 16'hBBBB, "R2");
    // R7: snooped read miss on Exclusive
    snoopOp(2'b01, 8'h10, 1, 16'hBBBB, "R7");
    cpuOp(0, 8'h10, 16'h0, 1, 16'hBBBB, "R7");
    expectBus(2'b10, 8'h10, 16'h0, "R7");
    cpuOp(1, 8'h10, 16'hCCCC, 0, 16'h0, "R7");
    // R11: unrelated snoop; R8: snooped write miss on Exclusive
    snoopOp(2'b01, 8'h22, 0, 16'h0, "R11");
    snoopOp(2'b10, 8'h10, 1, 16'hCCCC, "R8");
    expectBus(2'b01, 8'h10, 16'h0, "R8");
    cpuOp(0, 8'h10, 16'h0, 0, 16'h10EF, "R8");
    // R6: snooped write miss on Shared
    snoopOp(2'b10, 8'h10, 0, 16'h0, "R6");
    expectBus(2'b01, 8'h10, 16'h0, "R6");
    cpuOp(0, 8'h10, 16'h0, 0, 16'h10EF, "R6");
    // R4: write from Invalid
    snoopOp(2'b10, 8'h10, 0, 16'h0, "R6");
    expectBus(2'b10, 8'h30, 16'h0, "R4");
    cpuOp(1, 8'h30, 16'h1234, 0, 16'h0, "R4");
    cpuOp(1, 8'h30, 16'h1235, 1, 16'h0, "R4");
    // R9: read miss evicting Exclusive
    expectBus(2'b11, 8'h30, 16'h1235, "R9");
    expectBus(2'b01, 8'h40, 16'h0, "R9");
    cpuOp(0, 8'h40, 16'h0, 0, 16'h40BF, "R9");
    cpuOp(0, 8'h40, 16'h0, 1, 16'h40BF, "R9");
    // R10: write miss evicting Exclusive
    expectBus(2'b10, 8'h40, 16'h0, "R5");
    cpuOp(1, 8'h40, 16'h5555, 0, 16'h0, "R5");
    expectBus(2'b11, 8'h40, 16'h5555, "R10");
    expectBus(2'b10, 8'h50, 16'h0, "R10");
    cpuOp(1, 8'h50, 16'h6666, 0, 16'h0, "R10");
    cpuOp(1, 8'h50, 16'h6667, 1, 16'h0, "R10");
    // R11: victim downgraded while waiting, no write-back follows
    allowGrant = 1'b0;
    expectBus(2'b01, 8'h60, 16'h0, "R11");
    fork
      cpuOp(0, 8'h60, 16'h0, 0, 16'h609F, "R11");
      begin
        @(posedge clk);
        snoopOp(2'b01, 8'h50, 1, 16'h6667, "R11");
        allowGrant = 1'b1;
      end
    join
    // R11: upgrade invalidated while waiting still ends Exclusive
    allowGrant = 1'b0;
    expectBus(2'b10, 8'h60, 16'h0, "R11");
    fork
      cpuOp(1, 8'h60, 16'h7777, 0, 16'h0, "R11");
      begin
        @(posedge clk);
        snoopOp(2'b10, 8'h60, 0, 16'h0, "R11");
        allowGrant = 1'b1;
      end
    join
    cpuOp(0, 8'h60, 16'h0, 1, 16'h7777, "R11");
    // R12: a snoop cycle holds a processor hit
    @(posedge clk); #1;
    snpValid = 1'b1; snpCmd = 2'b01; snpAddr = 8'h99;
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = 8'h60;
    @(negedge clk);
    check("R12", "cpuDone during snoop", {31'd0, cpuDone}, 32'd0);
    @(posedge clk); #1;
    snpValid = 1'b0;
    @(negedge clk);
    check("R12", "cpuDone after snoop", {31'd0, cpuDone}, 32'd1);
    check("R12", "read data after snoop", {16'd0, cpuRdata}, 32'h7777);
    @(posedge clk); #1;
    cpuReq = 1'b0;
    repeat (2) @(posedge clk);
    check("R3", "unmatched expected bus items", expQ.size(), 0);
    finishRun();
  end

endmodule